// File: doc/BRIEF.md
# Nine-Value Rank Sorter

This block puts nine unsigned values into ascending order with a fixed latency of two clock cycles. A caller presents all nine values on one flat bus and raises a start strobe for one cycle. Two cycles later the sorted set appears on the output bus, marked by a one-cycle valid strobe. A new set may be presented on every cycle. Results leave in the order their sets were accepted.

The block does not use a compare-and-swap network. Each value is compared with the eight other values, and all 72 comparisons run in the same cycle. Each result is stored as a separate bit. The number of set bits in a value's 8-bit result vector is the output slot that value goes to. A 256-entry table gives that count. Ties are settled by input index: when two values are equal, the one with the lower index gets the lower slot. So every slot receives exactly one value, duplicates included, and the sort is stable. The element width is a parameter.

Top module: `rank_sorter`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `out_valid` is 0 and every bit of `out_data` is 0.
- R2: A set sampled with `in_start` high at clock edge k produces `out_valid` high after edge k+1, for exactly one cycle per accepted set.
- R3: On `out_data`, slot p sits in bits [p*W +: W] and slot 0 holds the smallest value. Each slot is less than or equal to the next slot. Input element k is read from bits [k*W +: W] of `in_data`.
- R4: The sorted output is a permutation of the accepted input. The output multiset equals the input multiset, so the sum of the slots equals the sum of the inputs.
- R5: Duplicate values, including a set where all nine values are equal, give the correct ascending result, with each copy in its own slot. Between equal values, the one with the lower input index gets the lower slot.
- R6: Sets presented on consecutive cycles are all accepted, and their results appear on consecutive cycles in the same order.
- R7: While `out_valid` is low, `out_data` holds the last result. `in_data` sampled with `in_start` low has no effect.
- R8: Values are compared as unsigned. A value with its top bit set sorts above every value with its top bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_start | input | 1 | Accept the set on `in_data` at this edge |
| in_data | input | 9*W | Nine unsorted elements; element k is bits [k*W +: W] |
| out_valid | output | 1 | One-cycle strobe marking a new sorted result |
| out_data | output | 9*W | Sorted slots, ascending; slot p is bits [p*W +: W] |

## Verification
On every cycle, the assertions check four things: that valid comes out two cycles after a start, that adjacent output slots are in ascending order whenever valid is high, that the output sum matches the input sum from two cycles earlier, and that the output holds while valid is low. These checks cannot show that the output is the exact permutation of the input, or that ties follow the index order. Only the bench's scoreboard shows those, by comparing each result with a reference sort. It runs all-equal sets, sets with repeated values, sets at the ends of the unsigned range, and long back-to-back streams.

// File: rtl/rank_sort_pkg.sv
package rank_sort_pkg;

    localparam int NUM_ELEMS = 9;
    localparam int CMP_BITS  = NUM_ELEMS - 1;
    localparam int RANK_W    = $clog2(NUM_ELEMS);

    typedef logic [CMP_BITS-1:0] cmp_vec_t;
    typedef logic [RANK_W-1:0]   rank_t;

    // Stage-one word: a valid flag plus one "goes before me" vector per element
    typedef struct packed {
        logic                        valid;
        cmp_vec_t [NUM_ELEMS-1:0]    ahead;
    } rank_stage_t;

    // Number of ones in a comparison vector
    function automatic rank_t ones_in(input cmp_vec_t v);
        rank_t n;
        n = '0;
        for (int b = 0; b < CMP_BITS; b++) begin
            n = n + rank_t'(v[b]);
        end
        return n;
    endfunction

    // Bit position j of element self's vector refers to this other element
    function automatic int other_index(input int self, input int j);
        return (j < self) ? j : j + 1;
    endfunction

endpackage

// File: rtl/rank_popcount_rom.sv
module rank_popcount_rom
    import rank_sort_pkg::*;
(
    input  cmp_vec_t idx,
    output rank_t    count
);

    localparam int DEPTH = 1 << CMP_BITS;

    rank_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
        assign rom[g] = ones_in(cmp_vec_t'(g));
    end

    assign count = rom[idx];

endmodule

// File: rtl/rank_compare_stage.sv
module rank_compare_stage
    import rank_sort_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_start,
    input  logic [NUM_ELEMS*W-1:0]  in_data,
    output rank_stage_t             s1,
    output logic [NUM_ELEMS*W-1:0]  s1_data
);

    cmp_vec_t [NUM_ELEMS-1:0] ahead_d;

    // Bit j of ahead_d[i] is set when the other element must precede element i.
    // Lower-index equals precede; higher-index equals follow.
    always_comb begin
        for (int i = 0; i < NUM_ELEMS; i++) begin
            for (int j = 0; j < CMP_BITS; j++) begin
                int o;
                o = other_index(i, j);
                if (o < i)
                    ahead_d[i][j] = in_data[o*W +: W] <= in_data[i*W +: W];
                else
                    ahead_d[i][j] = in_data[o*W +: W] <  in_data[i*W +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= '0;
            s1_data <= '0;
        end else begin
            s1.valid <= in_start;
            if (in_start) begin
                s1.ahead <= ahead_d;
                s1_data  <= in_data;
            end
        end
    end

endmodule

// File: rtl/rank_scatter_stage.sv
module rank_scatter_stage
    import rank_sort_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  rank_stage_t             s1,
    input  logic [NUM_ELEMS*W-1:0]  s1_data,
    output logic                    out_valid,
    output logic [NUM_ELEMS*W-1:0]  out_data
);

    rank_t [NUM_ELEMS-1:0]    rank;
    logic  [NUM_ELEMS*W-1:0]  placed;

    for (genvar e = 0; e < NUM_ELEMS; e++) begin : g_rank
        rank_popcount_rom rom_i (
            .idx   (s1.ahead[e]),
            .count (rank[e])
        );
    end

    // Each slot collects the single element whose rank names it
    always_comb begin
        placed = '0;
        for (int p = 0; p < NUM_ELEMS; p++) begin
            for (int i = 0; i < NUM_ELEMS; i++) begin
                if (rank[i] == rank_t'(p))
                    placed[p*W +: W] = placed[p*W +: W] | s1_data[i*W +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1.valid;
            if (s1.valid)
                out_data <= placed;
        end
    end

endmodule

// File: rtl/rank_sorter.sv
module rank_sorter
    import rank_sort_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_start,
    input  logic [NUM_ELEMS*W-1:0]  in_data,
    output logic                    out_valid,
    output logic [NUM_ELEMS*W-1:0]  out_data
);

    rank_stage_t               s1;
    logic [NUM_ELEMS*W-1:0]    s1_data;
    logic                      s1_valid;

    rank_compare_stage #(.W(W)) cmp_i (
        .clk      (clk),
        .rst      (rst),
        .in_start (in_start),
        .in_data  (in_data),
        .s1       (s1),
        .s1_data  (s1_data)
    );

    assign s1_valid = s1.valid;

    rank_scatter_stage #(.W(W)) sct_i (
        .clk       (clk),
        .rst       (rst),
        .s1        (s1),
        .s1_data   (s1_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/rank_sorter_chk.sv
module rank_sorter_chk
    import rank_sort_pkg::*;
#(
    parameter int W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_start,
    input logic [NUM_ELEMS*W-1:0]  in_data,
    input logic                    s1_valid,
    input logic                    out_valid,
    input logic [NUM_ELEMS*W-1:0]  out_data
);

    localparam int SUM_W = W + RANK_W;

    logic [1:0]       since_rst;
    logic [SUM_W-1:0] in_sum;
    logic [SUM_W-1:0] out_sum;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    always_comb begin
        in_sum  = '0;
        out_sum = '0;
        for (int k = 0; k < NUM_ELEMS; k++) begin
            in_sum  = in_sum  + SUM_W'(in_data[k*W +: W]);
            out_sum = out_sum + SUM_W'(out_data[k*W +: W]);
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (out_valid == 1'b0 && out_data == '0));

    // R2
    start_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_start, 2)));

    // R2
    stage_follow_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

    // R4
    sum_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid) |-> (out_sum == $past(in_sum, 2)));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !out_valid) |-> $stable(out_data));

    for (genvar p = 0; p < NUM_ELEMS - 1; p++) begin : g_order
        // R3
        ascending_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_data[p*W +: W] <= out_data[(p+1)*W +: W]));
    end

endmodule

bind rank_sorter rank_sorter_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_start  (in_start),
    .in_data   (in_data),
    .s1_valid  (s1_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/rank_sorter_tb.sv
module rank_sorter_tb_top;
    import rank_sort_pkg::*;

    localparam int W  = 8;
    localparam int NW = NUM_ELEMS * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_start = 1'b0;
    logic [NW-1:0] in_data = '0;
    logic          out_valid;
    logic [NW-1:0] out_data;

    always #5 clk = ~clk;

    rank_sorter #(.W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_start  (in_start),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct {
        int            cyc;
        logic [NW-1:0] exp;
        string         tag;
    } item_t;

    item_t         sb[$];
    item_t         it;
    int            cyc = 0;
    int            tests = 0;
    int            fails = 0;
    bit            finished = 1'b0;
    bit            armed = 1'b0;
    logic [NW-1:0] last_out = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [NW-1:0] ref_sort(input logic [NW-1:0] v);
        logic [W-1:0]  a [NUM_ELEMS];
        logic [W-1:0]  t;
        logic [NW-1:0] r;
        for (int k = 0; k < NUM_ELEMS; k++) a[k] = v[k*W +: W];
        for (int x = 0; x < NUM_ELEMS; x++)
            for (int y = 0; y < NUM_ELEMS - 1 - x; y++)
                if (a[y] > a[y+1]) begin
                    t = a[y]; a[y] = a[y+1]; a[y+1] = t;
                end
        for (int k = 0; k < NUM_ELEMS; k++) r[k*W +: W] = a[k];
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [NW-1:0] v, input string tag);
        @(negedge clk);
        in_data  = v;
        in_start = 1'b1;
        sb.push_back('{cyc, ref_sort(v), tag});
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_start = 1'b0;
            for (int k = 0; k < NUM_ELEMS; k++) in_data[k*W +: W] = W'($urandom);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    tests++;
                    fails++;
                    $display("FAIL R2: got unexpected out_valid expected none");
                end else begin
                    it = sb.pop_front();
                    check_vec(it.tag, out_data, it.exp);
                    // R2: two-cycle latency, R6: in order
                    check_int("R2", cyc, it.cyc + 2);
                    last_out = out_data;
                    armed    = 1'b1;
                end
            end else if (armed) begin
                // R7: held while idle, inputs ignored
                check_vec("R7", out_data, last_out);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] v;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check_int("R1", int'(out_valid), 0);
        check_vec("R1", out_data, '0);
        rst = 1'b0;
        @(negedge clk);
        check_int("R1", int'(out_valid), 0);
        check_vec("R1", out_data, '0);

        // R3: already ascending and fully reversed
        for (int k = 0; k < NUM_ELEMS; k++) v[k*W +: W] = W'(k * 3);
        send(v, "R3");
        for (int k = 0; k < NUM_ELEMS; k++) v[k*W +: W] = W'(200 - k * 7);
        send(v, "R3");
        idle(3);

        // R5: all values equal, then mixed duplicates
        for (int k = 0; k < NUM_ELEMS; k++) v[k*W +: W] = 8'h5A;
        send(v, "R5");
        v = {8'd1, 8'd3, 8'd0, 8'd7, 8'd7, 8'd1, 8'd3, 8'd7, 8'd3};
        send(v, "R5");
        idle(2);

        // R8: unsigned extremes around the top bit
        v = {8'hFF, 8'h00, 8'h80, 8'h7F, 8'h81, 8'h01, 8'hFE, 8'h7E, 8'h80};
        send(v, "R8");
        // R7: idle with random garbage on in_data
        idle(5);

        // R6: back-to-back stream with many repeats
        for (int s = 0; s < 40; s++) begin
            for (int k = 0; k < NUM_ELEMS; k++) v[k*W +: W] = W'($urandom_range(0, 3));
            send(v, "R6");
        end
        idle(4);

        // R4: full-range random sets, some with gaps
        for (int s = 0; s < 60; s++) begin
            for (int k = 0; k < NUM_ELEMS; k++) v[k*W +: W] = W'($urandom);
            send(v, "R4");
            if (s % 7 == 3) idle(2);
        end
        idle(5);

        // R6: every accepted set produced a result
        check_int("R6", sb.size(), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule